// File: doc/BRIEF.md
# Multi-channel interrupt status aggregator

This block holds the interrupt flags of up to sixteen data-transfer channels and presents them through one 16-bit status word. Each channel has three sticky flags: suspend, transfer done and transfer error. Each is set by a single-cycle pulse from that channel's logic. Each channel also reports three live levels: pending, busy and fetch error. All six values are seen through an indirect window. A 4-bit channel selector in the word decides which channel the status bits show and which channel a write-one clear acts on.

The selector also tracks which channel to service next. Whenever the selection is refreshed, it moves to the lowest-numbered channel that has any flag set. A refresh happens in two cases: a flag is raised on a channel below the current selection, or software clears flags. Software can instead point the selector at any channel by writing the word with all three clear bits at zero. That choice holds until the next refresh. A single registered interrupt request is high while any flag of any channel is set.

Top module: `chan_irq_status`

## Requirements
- R1: After reset, every flag is zero, the selector is 0 and `irq_o` is low. Bits 9:4 of the read word are always zero.
- R2: Bits 15, 14 and 13 of the read word show the pending, busy and fetch-error levels of the selected channel.
- R3: Bits 12, 11 and 10 show the suspend, done and error flags of the selected channel. A one-cycle set pulse makes the flag read one from the next cycle on.
- R4: A write with bit 12, 11 or 10 at one clears that flag (suspend, done, error respectively) of the channel given in bits 3:0 of the written data. A write with any of these bits at zero leaves the matching flag unchanged on every channel.
- R5: When a set pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R6: A refresh happens when a set pulse arrives on a channel numbered below the current selector, or when a pulse arrives while no flag was set anywhere. A refresh loads the selector with the lowest channel whose flags are non-zero after that cycle's updates, or 0 if there is none.
- R7: Any write with at least one of bits 12:10 at one is also a refresh. It takes effect in the same cycle as the clear and uses the post-clear flags.
- R8: A write with bits 12:10 all zero loads bits 3:0 into the selector, unless the same cycle is a refresh. The value then holds while pulses arrive only on channels at or above it.
- R9: While no flag is set on any channel, bits 3:0 of the read word are zero. The status bits still follow the held selector.
- R10: `irq_o` is high exactly when at least one flag is set, and it changes on the same clock edge as the flags.
- R11: `rd_data_o` is all zero while `rd_en_i` is low. While `rd_en_i` is high, it is a combinational view of the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_set_i | input | NUM_CH | Per-channel suspend event pulses |
| done_set_i | input | NUM_CH | Per-channel transfer-done event pulses |
| err_set_i | input | NUM_CH | Per-channel transfer-error event pulses |
| pend_i | input | NUM_CH | Per-channel pending level |
| busy_i | input | NUM_CH | Per-channel busy level |
| ferr_i | input | NUM_CH | Per-channel fetch-error level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read enable |
| rd_data_o | output | 16 | Register read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The checker enforces on every cycle the rules that follow directly from the state:
- reserved bits read zero;
- a set pulse always lands, even against a clear;
- no flag drops without a matching write-one;
- the request line follows the flag set;
- the read port is silent when not enabled;
- the selector reads zero when nothing is pending.

Only the bench scenarios can show which channel the selector settles on. That covers descending and ascending arrivals, refresh after clears, a software choice holding against higher-numbered arrivals, and a long stretch of mixed random traffic compared against an arithmetic reference.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned MAX_IDW = 4;
  // flag kinds
  localparam int unsigned K_SUSP = 0;
  localparam int unsigned K_DONE = 1;
  localparam int unsigned K_ERR  = 2;
  localparam int unsigned N_KIND = 3;
  // word layout
  localparam int unsigned B_PEND = 15;
  localparam int unsigned B_BUSY = 14;
  localparam int unsigned B_FERR = 13;
  localparam int unsigned B_SUSP = 12;
  localparam int unsigned B_DONE = 11;
  localparam int unsigned B_ERR  = 10;
endpackage

// File: rtl/chan_flag_bank.sv
module chan_flag_bank #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_q_o,
  output logic [NUM_CH-1:0] flag_d_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // set dominates clear
    assign flag_d_o[c] = (flag_q_o[c] & ~clr_i[c]) | set_i[c];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q_o[c] <= 1'b0;
      else         flag_q_o[c] <= flag_d_o[c];
    end
  end
endmodule

// File: rtl/lowest_pend_enc.sv
module lowest_pend_enc #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ID_W   = 4
) (
  input  logic [NUM_CH-1:0] vec_i,
  output logic [ID_W-1:0]   idx_o,
  output logic              any_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/status_rd_mux.sv
module status_rd_mux
  import chan_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ID_W   = 4
) (
  input  logic                          rd_en_i,
  input  logic [ID_W-1:0]               sel_i,
  input  logic                          any_i,
  input  logic [NUM_CH-1:0]             pend_i,
  input  logic [NUM_CH-1:0]             busy_i,
  input  logic [NUM_CH-1:0]             ferr_i,
  input  logic [N_KIND-1:0][NUM_CH-1:0] flag_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word         = '0;
    word[B_PEND] = pend_i[sel_i];
    word[B_BUSY] = busy_i[sel_i];
    word[B_FERR] = ferr_i[sel_i];
    word[B_SUSP] = flag_i[K_SUSP][sel_i];
    word[B_DONE] = flag_i[K_DONE][sel_i];
    word[B_ERR]  = flag_i[K_ERR][sel_i];
    // selector reads zero when nothing is flagged
    word[ID_W-1:0] = any_i ? sel_i : '0;
    rd_data_o = rd_en_i ? word : '0;
  end
endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
  import chan_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] susp_set_i,
  input  logic [NUM_CH-1:0] done_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] ferr_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [15:0]       rd_data_o,
  output logic              irq_o
);
  logic [N_KIND-1:0][NUM_CH-1:0] set_v, clr_v, flag_q, flag_d;
  logic [N_KIND-1:0]             clr_bit;
  logic [NUM_CH-1:0]             tgt_oh, below_m, arr_v, pend_q, pend_d;
  logic [ID_W-1:0]               sel_q, sel_d, tgt, low_d, low_q_unused;
  logic                          any_q, any_d, clr_hit, refresh, irq_q;

  assign set_v[K_SUSP] = susp_set_i;
  assign set_v[K_DONE] = done_set_i;
  assign set_v[K_ERR]  = err_set_i;

  assign clr_bit[K_SUSP] = wr_data_i[B_SUSP];
  assign clr_bit[K_DONE] = wr_data_i[B_DONE];
  assign clr_bit[K_ERR]  = wr_data_i[B_ERR];

  assign tgt     = wr_data_i[ID_W-1:0];
  assign tgt_oh  = {{(NUM_CH-1){1'b0}}, 1'b1} << tgt;
  assign clr_hit = wr_en_i & (|clr_bit);

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    assign clr_v[k] = (wr_en_i & clr_bit[k]) ? tgt_oh : '0;
    chan_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[k]),
      .clr_i    (clr_v[k]),
      .flag_q_o (flag_q[k]),
      .flag_d_o (flag_d[k])
    );
  end

  assign pend_q = flag_q[K_SUSP] | flag_q[K_DONE] | flag_q[K_ERR];
  assign pend_d = flag_d[K_SUSP] | flag_d[K_DONE] | flag_d[K_ERR];
  assign arr_v  = susp_set_i | done_set_i | err_set_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_below
    assign below_m[c] = (ID_W'(c) < sel_q);
  end

  lowest_pend_enc #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_enc_d (
    .vec_i (pend_d),
    .idx_o (low_d),
    .any_o (any_d)
  );

  lowest_pend_enc #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_enc_q (
    .vec_i (pend_q),
    .idx_o (low_q_unused),
    .any_o (any_q)
  );

  assign refresh = clr_hit | (|(arr_v & below_m)) | (~any_q & (|arr_v));

  always_comb begin
    sel_d = sel_q;
    if (refresh)      sel_d = low_d;
    else if (wr_en_i) sel_d = tgt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      irq_q <= any_d;
    end
  end

  assign irq_o = irq_q;

  status_rd_mux #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_rd (
    .rd_en_i   (rd_en_i),
    .sel_i     (sel_q),
    .any_i     (any_q),
    .pend_i    (pend_i),
    .busy_i    (busy_i),
    .ferr_i    (ferr_i),
    .flag_i    (flag_q),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/chan_irq_status_chk.sv
module chan_irq_status_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CH-1:0]      susp_set_i,
  input logic [NUM_CH-1:0]      done_set_i,
  input logic [NUM_CH-1:0]      err_set_i,
  input logic                   wr_en_i,
  input logic [15:0]            wr_data_i,
  input logic                   rd_en_i,
  input logic [2:0][NUM_CH-1:0] flag_q,
  input logic [15:0]            rd_data_o,
  input logic                   irq_o
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[9:4] == 6'b0);

  // R5
  susp_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_set_i != '0) |=> ((flag_q[0] & $past(susp_set_i)) == $past(susp_set_i)));

  // R5
  done_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i != '0) |=> ((flag_q[1] & $past(done_set_i)) == $past(done_set_i)));

  // R5
  err_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((flag_q[2] & $past(err_set_i)) == $past(err_set_i)));

  // R4
  susp_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[12]) |=> (($past(flag_q[0]) & ~flag_q[0]) == '0));

  // R4
  done_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[11]) |=> (($past(flag_q[1]) & ~flag_q[1]) == '0));

  // R4
  err_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[10]) |=> (($past(flag_q[2]) & ~flag_q[2]) == '0));

  // R10
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_q != '0));

  // R11
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == 16'h0);

  // R9
  sel_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && flag_q == '0) |-> rd_data_o[3:0] == 4'h0);
endmodule

bind chan_irq_status chan_irq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .susp_set_i (susp_set_i),
  .done_set_i (done_set_i),
  .err_set_i  (err_set_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .flag_q     (flag_q),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o)
);

// File: tb/chan_irq_status_bench.sv
`timescale 1ns/1ps
module chan_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] susp_set = '0, done_set = '0, err_set = '0;
  logic [15:0] pend_lv = 16'hC3A5, busy_lv = 16'h5A0F, ferr_lv = 16'h9124;
  logic        wr_en = 1'b0, rd_en = 1'b1;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] ms = '0, md = '0, me = '0;
  logic [3:0]  mid = '0;

  always #2.5 clk = ~clk;

  chan_irq_status u_chan_irq_status (
    .clk_i(clk), .rst_ni(rst_n),
    .susp_set_i(susp_set), .done_set_i(done_set), .err_set_i(err_set),
    .pend_i(pend_lv), .busy_i(busy_lv), .ferr_i(ferr_lv),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    logic        any;
    any = |(ms | md | me);
    w = '0;
    w[15] = pend_lv[mid]; w[14] = busy_lv[mid]; w[13] = ferr_lv[mid];
    w[12] = ms[mid]; w[11] = md[mid]; w[10] = me[mid];
    w[3:0] = any ? mid : 4'h0;
    return rd_en ? w : 16'h0;
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'h0;
  endfunction

  task automatic model(input logic [15:0] s, d, e, input logic wr, input logic [15:0] wd);
    logic anyb, clr, below, refr;
    logic [3:0] t;
    anyb = |(ms | md | me);
    t = wd[3:0];
    clr = wr && (|wd[12:10]);
    below = 1'b0;
    for (int c = 0; c < 16; c++) if ((s[c] | d[c] | e[c]) && 4'(c) < mid) below = 1'b1;
    if (wr && wd[12]) ms[t] = 1'b0;
    if (wr && wd[11]) md[t] = 1'b0;
    if (wr && wd[10]) me[t] = 1'b0;
    ms = ms | s; md = md | d; me = me | e;
    refr = clr || below || (!anyb && (|(s | d | e)));
    if (refr)    mid = lowest(ms | md | me);
    else if (wr) mid = t;
  endtask

  task automatic step(input logic [15:0] s, d, e, input logic wr, input logic [15:0] wd);
    @(negedge clk);
    susp_set = s; done_set = d; err_set = e; wr_en = wr; wr_data = wd;
    model(s, d, e, wr, wd);
    @(posedge clk); #1;
  endtask

  task automatic idle();
    step('0, '0, '0, 1'b0, '0);
  endtask

  task automatic check_state(input string tag);
    chk(tag, rd_data, exp_word());
    chk({tag, "/R10"}, {15'b0, irq}, {15'b0, |(ms | md | me)});
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 chk("R1 reset word", rd_data, {pend_lv[0], busy_lv[0], ferr_lv[0], 13'b0});
    chk("R1 reset irq", {15'b0, irq}, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    // R2, R9: walk selector across all channels with nothing flagged
    for (int c = 0; c < 16; c++) begin
      step('0, '0, '0, 1'b1, 16'(c));
      check_state("R2 R9 select sweep");
    end

    // R3, R6: descending error arrivals move the selector down
    for (int c = 15; c >= 0; c--) begin
      step('0, '0, 16'(1) << c, 1'b0, '0);
      check_state("R3 R6 descending arrival");
    end

    // R4, R7: clear error flags upward, selector follows the next lowest
    for (int c = 0; c < 16; c++) begin
      step('0, '0, '0, 1'b1, 16'h0400 | 16'(c));
      check_state("R4 R7 ascending clear");
    end
    chk("R9 idle id", {12'b0, rd_data[3:0]}, 16'h0);

    // R3, R6: ascending arrivals keep the selector at the first one
    for (int c = 0; c < 16; c++) begin
      step(16'(1) << c, (c % 3 == 0) ? (16'(1) << c) : 16'h0, '0, 1'b0, '0);
      check_state("R3 R6 ascending arrival");
    end

    // R4: writing zero clear bits leaves flags, only moves selector (R8)
    step('0, '0, '0, 1'b1, 16'h0009);
    check_state("R4 R8 write zero bits");

    // R8: arrivals at/above the software choice do not move it
    step('0, '0, 16'hFE00, 1'b0, '0);
    check_state("R8 hold against higher");
    step('0, '0, '0, 1'b1, 16'h0005);
    check_state("R8 reselect");
    step('0, 16'h0020, '0, 1'b0, '0);
    check_state("R8 hold same channel");

    // R5: set and clear collide on channel 5 suspend
    step(16'h0020, '0, '0, 1'b1, 16'h1005);
    check_state("R5 set wins");

    // R7: clear all kinds on channel 0 refreshes to channel 1
    step('0, '0, '0, 1'b1, 16'h1C00);
    check_state("R7 clear refresh");

    // R6: arrival below a high software choice refreshes
    step('0, '0, '0, 1'b1, 16'h000E);
    check_state("R8 high choice");
    step('0, '0, 16'h0002, 1'b0, '0);
    check_state("R6 lower arrival");

    // R11: read enable low silences the port
    rd_en = 1'b0; #1;
    chk("R11 read disabled", rd_data, 16'h0);
    rd_en = 1'b1; #1;

    // mixed random traffic with changing levels
    for (int n = 0; n < 600; n++) begin
      logic w;
      logic [15:0] wd;
      pend_lv = 16'($urandom); busy_lv = 16'($urandom); ferr_lv = 16'($urandom);
      w  = ($urandom % 4) == 0;
      wd = 16'($urandom);
      step(16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
           16'($urandom & $urandom & $urandom & $urandom), w, wd);
      check_state("R3 R4 R6 R7 R8 random");
    end

    // drain all flags channel by channel
    for (int c = 0; c < 16; c++) step('0, '0, '0, 1'b1, 16'h1C00 | 16'(c));
    idle();
    check_state("R9 R10 drained");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule